// File: doc/BRIEF.md
# Eight-bit ALU with status-flag update and condition test

This block is the arithmetic and logic unit of a small RISC core's execute stage. Each cycle the core presents an operation code, a register operand, a second operand chosen from a register or an immediate, and the current eight-bit status word. The block is purely combinational. It returns the eight-bit result, a result write strobe, the next value of every status bit, and a per-bit write mask. Each operation touches only its own set of flags. Flags outside that set are passed through unchanged, so the core can write the whole status word back every cycle.

A separate condition evaluator resolves conditional branches and skips against the current status word. It compares one selected flag with a wanted polarity. A signed mode instead tests the exclusive-OR of negative and overflow. The register file, program counter, memory access, word-wide operations and interrupts all sit outside this block.

The status word has carry at bit 0, zero at bit 1, negative at bit 2, overflow at bit 3, sign at bit 4, half-carry at bit 5, transfer bit at bit 6 and interrupt enable at bit 7. The flag-select input of the condition evaluator uses these bit positions.

Top module: `alu8_core`

## Requirements
- R1: Add (code 0x00) returns A+B and add-with-carry (0x01) returns A+B+C. Both write Z, C, N, V, H and S. C is the carry out of bit 7, H is the carry out of bit 3, and V is set on two's-complement overflow.
- R2: Subtract (0x02), subtract-with-carry (0x03) and negate (0x06, result 0x00−A) write Z, C, N, V, H and S. C is the borrow out of bit 7, H is the borrow out of bit 3, and subtract-with-carry also subtracts the incoming C.
- R3: Compare (0x04) and compare-with-carry (0x05) produce the same flags as subtract and subtract-with-carry, but hold the result write strobe low. Every other code drives it high.
- R4: For subtract-with-carry and compare-with-carry, Z becomes 0 on a nonzero result and otherwise keeps its incoming value.
- R5: AND (0x07), OR (0x08), XOR (0x09) and clear-bits (0x0A, A AND NOT B) write only Z, N, V and S. V is forced to 0, and C and H are kept.
- R6: Complement (0x0B) returns 0xFF−A and writes Z, C, N, V and S. C is forced to 1 and V to 0.
- R7: Increment (0x0C) and decrement (0x0D) write Z, N, V and S only. V is set when the operand is 0x7F for increment and 0x80 for decrement. C and H are kept.
- R8: Rotate right (0x10) moves the old C into bit 7 and bit 0 into C. Rotate left (0x11) moves the old C into bit 0 and bit 7 into C. Both write Z, C, N, V and S, with V = N xor C.
- R9: Logical shift right (0x0E) puts 0 into bit 7. Arithmetic shift right (0x0F) keeps bit 7. Both move bit 0 into C and write Z, C, N, V and S, with V = N xor C.
- R10: Nibble swap (0x12) exchanges bits 7:4 with bits 3:0. Move (0x13), and every code above 0x13, returns the second operand. None of these writes any flag.
- R11: Whenever S is written it equals the new N xor the new V. Every flag whose mask bit is 0 leaves the block equal to its incoming value.
- R12: With signed mode low, the condition output is 1 exactly when the status bit at the selected position equals the polarity input. With signed mode high, it is 1 exactly when N xor V equals the polarity input, so polarity 1 means signed less-than and polarity 0 means signed greater-or-equal.
- R13: With the immediate select high, the immediate input replaces the register B operand in every two-operand operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 5 | Operation code |
| reg_a | input | 8 | First operand, also the operand of single-operand operations |
| reg_b | input | 8 | Register second operand |
| imm_k | input | 8 | Immediate second operand |
| use_imm | input | 1 | Selects imm_k instead of reg_b |
| flags_in | input | 8 | Current status word |
| cond_sel | input | 3 | Status bit position tested by the condition evaluator |
| cond_pol | input | 1 | Wanted value of the tested condition |
| cond_signed | input | 1 | Tests N xor V instead of the selected bit |
| result | output | 8 | Operation result |
| result_we | output | 1 | Result should be written back |
| flags_next | output | 8 | Next status word |
| flags_we | output | 8 | Per-bit status write mask |
| cond_take | output | 1 | Condition met |

## Verification
The block holds no state, so any fault shows at the ports in the same cycle as the operands that expose it. The main concern is a wrong flag-mask decode. It would show as a carry that changes on increment or on a logic operation, as a written flag that should be kept, or as a zero flag that fails to chain across bytes. Each of these is visible only for certain incoming status words. The stimulus therefore drives every code with random operands and random status words, under both carry-in values. It then adds the overflow, borrow and zero-chain corner cases.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW    = 8;
    localparam int NIB   = DW / 2;
    localparam int FW    = 8;
    localparam int SEL_W = $clog2(FW);
    localparam int OP_W  = 5;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;

    localparam logic [FW-1:0] MASK_ARITH = FW'(1 << FL_Z) | FW'(1 << FL_C) | FW'(1 << FL_N)
                                         | FW'(1 << FL_V) | FW'(1 << FL_S) | FW'(1 << FL_H);
    localparam logic [FW-1:0] MASK_LOGIC = FW'(1 << FL_Z) | FW'(1 << FL_N)
                                         | FW'(1 << FL_V) | FW'(1 << FL_S);
    localparam logic [FW-1:0] MASK_SHIFT = MASK_LOGIC | FW'(1 << FL_C);

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'h00,
        OP_ADC  = 5'h01,
        OP_SUB  = 5'h02,
        OP_SBC  = 5'h03,
        OP_CP   = 5'h04,
        OP_CPC  = 5'h05,
        OP_NEG  = 5'h06,
        OP_AND  = 5'h07,
        OP_OR   = 5'h08,
        OP_XOR  = 5'h09,
        OP_ANDN = 5'h0A,
        OP_COM  = 5'h0B,
        OP_INC  = 5'h0C,
        OP_DEC  = 5'h0D,
        OP_LSR  = 5'h0E,
        OP_ASR  = 5'h0F,
        OP_ROR  = 5'h10,
        OP_ROL  = 5'h11,
        OP_SWAP = 5'h12,
        OP_MOV  = 5'h13
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          c;
        logic          h;
        logic          v;
        logic          n;
        logic          z;
        logic          s;
    } unit_out_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          cin,
    input  logic          sub,
    input  logic          z_prev,
    input  logic          z_chain,
    output unit_out_t     o
);
    logic [DW-1:0]  y_eff;
    logic           c_eff;
    logic [DW:0]    full_sum;
    logic [NIB:0]   low_sum;
    logic           zero_res;

    always_comb begin
        // Subtraction as x + ~y + ~cin; borrows are inverted carries.
        y_eff    = sub ? ~y : y;
        c_eff    = sub ? ~cin : cin;
        full_sum = {1'b0, x} + {1'b0, y_eff} + {{DW{1'b0}}, c_eff};
        low_sum  = {1'b0, x[NIB-1:0]} + {1'b0, y_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
        o.res    = full_sum[DW-1:0];
        o.c      = sub ? ~full_sum[DW] : full_sum[DW];
        o.h      = sub ? ~low_sum[NIB] : low_sum[NIB];
        o.v      = (x[DW-1] == y_eff[DW-1]) && (full_sum[DW-1] != x[DW-1]);
        o.n      = full_sum[DW-1];
        zero_res = (full_sum[DW-1:0] == '0);
        o.z      = z_chain ? (zero_res & z_prev) : zero_res;
        o.s      = o.n ^ o.v;
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          cin,
    output unit_out_t     o
);
    logic is_shift;
    logic is_com;

    always_comb begin
        is_shift = 1'b0;
        is_com   = 1'b0;
        o.c      = cin;
        o.h      = 1'b0;
        unique case (op)
            OP_AND:  o.res = x & y;
            OP_OR:   o.res = x | y;
            OP_XOR:  o.res = x ^ y;
            OP_ANDN: o.res = x & ~y;
            OP_COM: begin
                o.res  = ~x;
                is_com = 1'b1;
            end
            OP_LSR: begin
                o.res    = {1'b0, x[DW-1:1]};
                o.c      = x[0];
                is_shift = 1'b1;
            end
            OP_ASR: begin
                o.res    = {x[DW-1], x[DW-1:1]};
                o.c      = x[0];
                is_shift = 1'b1;
            end
            OP_ROR: begin
                o.res    = {cin, x[DW-1:1]};
                o.c      = x[0];
                is_shift = 1'b1;
            end
            OP_ROL: begin
                o.res    = {x[DW-2:0], cin};
                o.c      = x[DW-1];
                is_shift = 1'b1;
            end
            OP_SWAP: o.res = {x[NIB-1:0], x[DW-1:NIB]};
            default: o.res = y;
        endcase
        if (is_com) begin
            o.c = 1'b1;
        end
        o.n = o.res[DW-1];
        o.z = (o.res == '0);
        o.v = is_shift ? (o.n ^ o.c) : 1'b0;
        o.s = o.n ^ o.v;
    end
endmodule

// File: rtl/alu8_cond.sv
module alu8_cond
    import alu8_pkg::*;
(
    input  logic [FW-1:0]    flags,
    input  logic [SEL_W-1:0] sel,
    input  logic             pol,
    input  logic             signed_mode,
    output logic             take
);
    logic picked;

    always_comb begin
        picked = signed_mode ? (flags[FL_N] ^ flags[FL_V]) : flags[sel];
        take   = (picked == pol);
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic [DW-1:0]    reg_a,
    input  logic [DW-1:0]    reg_b,
    input  logic [DW-1:0]    imm_k,
    input  logic             use_imm,
    input  logic [FW-1:0]    flags_in,
    input  logic [SEL_W-1:0] cond_sel,
    input  logic             cond_pol,
    input  logic             cond_signed,
    output logic [DW-1:0]    result,
    output logic             result_we,
    output logic [FW-1:0]    flags_next,
    output logic [FW-1:0]    flags_we,
    output logic             cond_take
);
    localparam logic [DW-1:0] ONE = DW'(1);

    alu_op_e       op_e;
    logic [DW-1:0] opnd_b;
    logic [DW-1:0] as_x;
    logic [DW-1:0] as_y;
    logic          as_cin;
    logic          as_sub;
    logic          as_chain;
    logic          use_adder;
    unit_out_t     add_o;
    unit_out_t     bit_o;
    unit_out_t     sel_o;
    logic [FW-1:0] fresh;

    assign op_e   = alu_op_e'(op);
    assign opnd_b = use_imm ? imm_k : reg_b;

    // Operand steering for the adder and flag mask decode
    always_comb begin
        as_x      = reg_a;
        as_y      = opnd_b;
        as_cin    = 1'b0;
        as_sub    = 1'b0;
        as_chain  = 1'b0;
        use_adder = 1'b1;
        flags_we  = MASK_ARITH;
        result_we = 1'b1;
        unique case (op_e)
            OP_ADD: ;
            OP_ADC: as_cin = flags_in[FL_C];
            OP_SUB: as_sub = 1'b1;
            OP_SBC: begin
                as_sub   = 1'b1;
                as_cin   = flags_in[FL_C];
                as_chain = 1'b1;
            end
            OP_CP: begin
                as_sub    = 1'b1;
                result_we = 1'b0;
            end
            OP_CPC: begin
                as_sub    = 1'b1;
                as_cin    = flags_in[FL_C];
                as_chain  = 1'b1;
                result_we = 1'b0;
            end
            OP_NEG: begin
                as_x   = '0;
                as_y   = reg_a;
                as_sub = 1'b1;
            end
            OP_INC: begin
                as_y     = ONE;
                flags_we = MASK_LOGIC;
            end
            OP_DEC: begin
                as_y     = ONE;
                as_sub   = 1'b1;
                flags_we = MASK_LOGIC;
            end
            OP_AND, OP_OR, OP_XOR, OP_ANDN: begin
                use_adder = 1'b0;
                flags_we  = MASK_LOGIC;
            end
            OP_COM, OP_LSR, OP_ASR, OP_ROR, OP_ROL: begin
                use_adder = 1'b0;
                flags_we  = MASK_SHIFT;
            end
            default: begin
                use_adder = 1'b0;
                flags_we  = '0;
            end
        endcase
    end

    alu8_addsub u_addsub (
        .x       (as_x),
        .y       (as_y),
        .cin     (as_cin),
        .sub     (as_sub),
        .z_prev  (flags_in[FL_Z]),
        .z_chain (as_chain),
        .o       (add_o)
    );

    alu8_bitops u_bitops (
        .op  (op_e),
        .x   (reg_a),
        .y   (opnd_b),
        .cin (flags_in[FL_C]),
        .o   (bit_o)
    );

    alu8_cond u_cond (
        .flags       (flags_in),
        .sel         (cond_sel),
        .pol         (cond_pol),
        .signed_mode (cond_signed),
        .take        (cond_take)
    );

    // Merge: masked-off bits keep their incoming value
    always_comb begin
        sel_o             = use_adder ? add_o : bit_o;
        fresh             = flags_in;
        fresh[FL_C]       = sel_o.c;
        fresh[FL_Z]       = sel_o.z;
        fresh[FL_N]       = sel_o.n;
        fresh[FL_V]       = sel_o.v;
        fresh[FL_S]       = sel_o.s;
        fresh[FL_H]       = sel_o.h;
        result            = sel_o.res;
        flags_next        = (flags_in & ~flags_we) | (fresh & flags_we);
    end

    // Assertions guarding the flag-update stage
    always_comb begin
        if (flags_we[FL_S]) begin
            assert_sign_is_n_xor_v_R11: assert (flags_next[FL_S] == (flags_next[FL_N] ^ flags_next[FL_V]));
        end
        if (op_e == OP_INC || op_e == OP_DEC) begin
            assert_incdec_keeps_carry_R7: assert (!flags_we[FL_C] && flags_next[FL_C] == flags_in[FL_C]);
        end
        if (op_e == OP_AND || op_e == OP_OR || op_e == OP_XOR || op_e == OP_ANDN) begin
            assert_logic_clears_v_R5: assert (flags_we[FL_V] && !flags_next[FL_V] && !flags_we[FL_C]);
        end
        if (op_e == OP_CP || op_e == OP_CPC) begin
            assert_compare_no_write_R3: assert (!result_we);
        end
        if (op_e == OP_COM) begin
            assert_com_sets_carry_R6: assert (flags_we[FL_C] && flags_next[FL_C]);
        end
        if (op_e == OP_SWAP) begin
            assert_swap_flags_quiet_R10: assert (flags_we == '0 && flags_next == flags_in);
        end
    end
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    typedef struct {
        logic [7:0] res;
        logic       res_we;
        logic [7:0] fl;
        logic [7:0] we;
        logic       take;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] reg_a = '0;
    logic [7:0] reg_b = '0;
    logic [7:0] imm_k = '0;
    logic       use_imm = 1'b0;
    logic [7:0] flags_in = '0;
    logic [2:0] cond_sel = '0;
    logic       cond_pol = 1'b0;
    logic       cond_signed = 1'b0;
    logic [7:0] result;
    logic       result_we;
    logic [7:0] flags_next;
    logic [7:0] flags_we;
    logic       cond_take;

    exp_t sb_q[$];
    exp_t mon_e;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core dut_i (
        .op          (op),
        .reg_a       (reg_a),
        .reg_b       (reg_b),
        .imm_k       (imm_k),
        .use_imm     (use_imm),
        .flags_in    (flags_in),
        .cond_sel    (cond_sel),
        .cond_pol    (cond_pol),
        .cond_signed (cond_signed),
        .result      (result),
        .result_we   (result_we),
        .flags_next  (flags_next),
        .flags_we    (flags_we),
        .cond_take   (cond_take)
    );

    function automatic int sx(input logic [7:0] v);
        return v[7] ? int'(v) - 256 : int'(v);
    endfunction

    function automatic string tag_of(input int code, input bit imm);
        string t;
        if (code <= 1) t = "R1";
        else if (code == 2 || code == 6) t = "R2";
        else if (code == 3) t = "R2/R4";
        else if (code == 4) t = "R3";
        else if (code == 5) t = "R3/R4";
        else if (code <= 10) t = "R5";
        else if (code == 11) t = "R6";
        else if (code <= 13) t = "R7";
        else if (code <= 15) t = "R9";
        else if (code <= 17) t = "R8";
        else t = "R10";
        if (imm) t = {t, "/R13"};
        return {t, "/R11/R12"};
    endfunction

    // Reference model, written from the requirements
    function automatic exp_t model(input int code, input logic [7:0] a8, input logic [7:0] rb,
                                   input logic [7:0] k, input bit imm, input logic [7:0] f,
                                   input logic [2:0] cs, input bit cp, input bit cm);
        exp_t e;
        int a = int'(a8);
        int b = imm ? int'(k) : int'(rb);
        int c = int'(f[0]);
        int r, s, sv, x, y, ci;
        bit nC = f[0], nZ, nN, nV = 1'b0, nH = f[5], nS;
        logic [7:0] mask;
        logic [7:0] nf;
        bit zchain = 1'b0;
        e.res_we = !(code == 4 || code == 5);
        case (code)
            0, 1: begin
                ci = (code == 1) ? c : 0;
                s = a + b + ci;
                r = s & 255;
                nC = s > 255;
                nH = ((a & 15) + (b & 15) + ci) > 15;
                sv = sx(a8) + sx(8'(b)) + ci;
                nV = (sv > 127) || (sv < -128);
                mask = 8'h3F;
            end
            2, 3, 4, 5, 6: begin
                if (code == 6) begin x = 0; y = a; ci = 0; end
                else begin x = a; y = b; ci = (code == 3 || code == 5) ? c : 0; end
                s = x - y - ci;
                r = s & 255;
                nC = s < 0;
                nH = ((x & 15) - (y & 15) - ci) < 0;
                sv = sx(8'(x)) - sx(8'(y)) - ci;
                nV = (sv > 127) || (sv < -128);
                zchain = (code == 3 || code == 5);
                mask = 8'h3F;
            end
            7:  begin r = a & b; mask = 8'h1E; end
            8:  begin r = a | b; mask = 8'h1E; end
            9:  begin r = a ^ b; mask = 8'h1E; end
            10: begin r = a & (255 - b); mask = 8'h1E; end
            11: begin r = 255 - a; nC = 1'b1; mask = 8'h1F; end
            12: begin r = (a + 1) & 255; nV = (a == 127); mask = 8'h1E; end
            13: begin r = (a + 255) & 255; nV = (a == 128); mask = 8'h1E; end
            14: begin r = a >> 1; nC = a[0]; mask = 8'h1F; end
            15: begin r = (a >> 1) | (a & 128); nC = a[0]; mask = 8'h1F; end
            16: begin r = (a >> 1) | (c << 7); nC = a[0]; mask = 8'h1F; end
            17: begin r = ((a << 1) | c) & 255; nC = a[7]; mask = 8'h1F; end
            18: begin r = ((a & 15) << 4) | (a >> 4); mask = 8'h00; end
            default: begin r = b; mask = 8'h00; end
        endcase
        nN = r >= 128;
        if (code >= 14 && code <= 17) nV = nN ^ nC;
        nZ = zchain ? ((r == 0) && f[1]) : (r == 0);
        nS = nN ^ nV;
        nf = {f[7], f[6], nH, nS, nV, nN, nZ, nC};
        e.res  = 8'(r);
        e.we   = mask;
        e.fl   = (f & ~mask) | (nf & mask);
        e.take = cm ? ((f[2] ^ f[3]) == cp) : (f[cs] == cp);
        e.tag  = tag_of(code, imm);
        return e;
    endfunction

    task automatic drive(input int code, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] k, input bit imm, input logic [7:0] f,
                         input logic [2:0] cs, input bit cp, input bit cm);
        @(posedge clk);
        op          = 5'(code);
        reg_a       = a;
        reg_b       = b;
        imm_k       = k;
        use_imm     = imm;
        flags_in    = f;
        cond_sel    = cs;
        cond_pol    = cp;
        cond_signed = cm;
        sb_q.push_back(model(code, a, b, k, imm, f, cs, cp, cm));
    endtask

    // Monitor: pop one expected item per cycle and compare
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            mon_e = sb_q.pop_front();
            checks++;
            if (result !== mon_e.res || result_we !== mon_e.res_we || flags_next !== mon_e.fl
                || flags_we !== mon_e.we || cond_take !== mon_e.take) begin
                errors++;
                $display("FAIL %s op=%h a=%h b=%h f=%h: got res=%h we=%b flags=%h mask=%h take=%b, expected res=%h we=%b flags=%h mask=%h take=%b",
                         mon_e.tag, op, reg_a, (use_imm ? imm_k : reg_b), flags_in,
                         result, result_we, flags_next, flags_we, cond_take,
                         mon_e.res, mon_e.res_we, mon_e.fl, mon_e.we, mon_e.take);
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got hang, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state after reset: add of zeros, Z set (R1)
        drive(0, 8'h00, 8'h00, 8'h00, 0, 8'h00, 3'd0, 0, 0);
        // Corner cases
        drive(0,  8'h7F, 8'h01, 8'h00, 0, 8'h00, 3'd1, 1, 0);   // R1 overflow and half carry
        drive(1,  8'hFF, 8'h00, 8'h00, 0, 8'h01, 3'd0, 1, 0);   // R1 carry in wraps to zero
        drive(2,  8'h00, 8'h01, 8'h00, 0, 8'h00, 3'd2, 0, 1);   // R2 borrow
        drive(3,  8'h05, 8'h05, 8'h00, 0, 8'h00, 3'd0, 0, 0);   // R4 zero result, Z in 0 stays 0
        drive(3,  8'h05, 8'h05, 8'h00, 0, 8'h02, 3'd1, 1, 0);   // R4 zero result, Z in 1 stays 1
        drive(5,  8'h10, 8'h0F, 8'h00, 0, 8'h03, 3'd0, 1, 0);   // R4 R3 compare-with-carry
        drive(4,  8'h80, 8'h01, 8'h00, 0, 8'h00, 3'd3, 1, 1);   // R3 signed overflow on compare
        drive(6,  8'h80, 8'h00, 8'h00, 0, 8'h00, 3'd0, 0, 0);   // R2 negate of 0x80
        drive(6,  8'h00, 8'h00, 8'h00, 0, 8'h21, 3'd5, 1, 0);   // R2 negate of zero
        drive(11, 8'h00, 8'h00, 8'h00, 0, 8'h00, 3'd0, 1, 0);   // R6
        drive(12, 8'h7F, 8'h00, 8'h00, 0, 8'h21, 3'd5, 1, 0);   // R7 carry and H kept
        drive(13, 8'h80, 8'h00, 8'h00, 0, 8'h00, 3'd0, 0, 0);   // R7
        drive(16, 8'h01, 8'h00, 8'h00, 0, 8'h01, 3'd0, 1, 0);   // R8 old carry to bit 7
        drive(17, 8'h80, 8'h00, 8'h00, 0, 8'h00, 3'd0, 1, 0);   // R8 bit 7 to carry
        drive(15, 8'h81, 8'h00, 8'h00, 0, 8'h00, 3'd0, 1, 0);   // R9
        drive(14, 8'h81, 8'h00, 8'h00, 0, 8'h00, 3'd0, 1, 0);   // R9
        drive(18, 8'hA5, 8'h00, 8'h00, 0, 8'hFF, 3'd7, 1, 0);   // R10
        drive(20, 8'h00, 8'h3C, 8'h00, 0, 8'hAA, 3'd6, 0, 0);   // R10 unused code
        drive(31, 8'h00, 8'h3C, 8'hC3, 1, 8'h55, 3'd6, 1, 0);   // R10 R13
        drive(10, 8'hFF, 8'h00, 8'h0F, 1, 8'h29, 3'd3, 0, 1);   // R5 R13 clear-bits
        drive(2,  8'h10, 8'hFF, 8'h01, 1, 8'h00, 3'd0, 0, 0);   // R13 subtract-immediate
        drive(0,  8'h00, 8'h00, 8'h00, 0, 8'h0C, 3'd0, 0, 1);   // R12 N=1 V=1 signed ge
        drive(0,  8'h00, 8'h00, 8'h00, 0, 8'h04, 3'd0, 1, 1);   // R12 N=1 V=0 signed lt
        // Random sweep over every code and both carry-in values
        for (int code = 0; code < 21; code++) begin
            for (int n = 0; n < 25; n++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    logic [7:0] f = 8'($urandom);
                    f[0] = ci[0];
                    drive(code, 8'($urandom), 8'($urandom), 8'($urandom), bit'($urandom & 1),
                          f, 3'($urandom), bit'($urandom & 1), bit'($urandom & 1));
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule